// File: doc/BRIEF.md
# Vector Multiply-Accumulate Unit with Pipelined Adder Tree

This block is one compute lane of a convolution engine. On every accepted input beat it takes a vector of signed 8-bit feature values and a vector of signed 8-bit weights of the same length. It multiplies them lane by lane and reduces the products to one sum through a registered binary adder tree. It then adds that sum into a running total that spans a window of beats. The stream marks each window with a first-beat flag and a last-beat flag, so the window length is set per window by the producer and may be any number of beats from one upward.

The running total is kept in a ring of delay registers whose depth equals the tree latency plus one. Each beat adds into the entry that left the ring several beats earlier, never into the value written on the cycle before. When the last beat of a window has been folded in, all ring entries are summed and a bias is added. An optional rectifier follows, then a rounding arithmetic right shift and saturation to a signed 8-bit result.

Both data streams use valid/ready. An input beat transfers on a clock edge where `in_valid` and `in_ready` are both high. A result transfers on an edge where `out_valid` and `out_ready` are both high. While a result waits with `out_ready` low, the whole pipeline stalls: `in_ready` drops, and no beat or result is lost. The configuration pins are plain levels. They are used in the cycle a result is formed, so they must stay steady from the first beat of a window until its result has been taken.

Top module: `vmac_unit`

## Requirements
- R1: Lane i of `in_feat` and `in_wgt` sits at bits [8i+7:8i] as a two's-complement byte. A window's sum is the sum over all its accepted beats and all lanes of feature times weight, kept modulo 2^32 as a signed 32-bit value.
- R2: A beat with `in_first` high begins a new window. No contribution from any earlier beat enters the new window's sum, even when the new window follows the previous last beat with no idle cycle.
- R3: Each accepted beat with `in_last` high yields exactly one result. With `out_ready` held high and the pipeline empty, `out_valid` rises log2(LANES)+2 clock edges after the edge that accepted that beat (4 edges at LANES=4).
- R4: The signed 32-bit `cfg_bias` is added to the window sum, with 32-bit wraparound, before rectification and shifting.
- R5: With `cfg_relu_en` high, a negative biased sum becomes zero. With `cfg_relu_en` low, a negative biased sum passes on unchanged.
- R6: The rectified value is shifted right arithmetically by `cfg_shift`. When `cfg_shift` is nonzero, 2^(cfg_shift-1) is added first, so halves round toward plus infinity. A shift of zero leaves the value unchanged.
- R7: The shifted value is clamped to the range -128 to 127 before it appears on `out_data` as a two's-complement byte.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold and `in_ready` is low. Results leave in window order with none dropped.
- R9: Cycles with `in_valid` low add nothing to any window sum, whatever the data and flag inputs carry.
- R10: After reset, `out_valid` is low and `in_ready` is high.
- R11: Windows of a single beat, and windows longer than the ring depth, both give the R1 to R7 result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Unit can take a beat this cycle |
| in_feat | input | LANES*8 | Feature vector, lane i at bits 8i+7:8i |
| in_wgt | input | LANES*8 | Weight vector, same lane layout |
| in_first | input | 1 | Beat opens a window |
| in_last | input | 1 | Beat closes a window |
| cfg_bias | input | 32 | Signed bias added to each window sum |
| cfg_relu_en | input | 1 | Clamp negative sums to zero |
| cfg_shift | input | 5 | Right shift applied before saturation |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 8 | Signed saturated result |

## Verification
The bench builds the unit with its defaults: four lanes, 8-bit operands, a 32-bit accumulator and a 5-bit shift field. That gives a two-level tree and a three-entry ring. At this size a one-beat window leaves two ring entries untouched, while a ten-beat window wraps the ring three times, so both the clearing done by the first-beat flag and the fold of all entries at window end are seen. Four lanes of 127 times 127 also exceed the 8-bit range quickly, which brings both saturation limits and the rounding of odd halves within reach with short windows.

// File: rtl/vmac_pkg.sv
package vmac_pkg;

  // Control carried alongside each beat as it moves down the pipeline.
  typedef struct packed {
    logic v;
    logic first;
    logic last;
  } beat_tag_t;

endpackage

// File: rtl/vmac_mul_lanes.sv
module vmac_mul_lanes #(
  parameter int LANES = 4,
  parameter int DW    = 8,
  parameter int ACCW  = 32
) (
  input  logic                  clk,
  input  logic                  en,
  input  logic [LANES*DW-1:0]   feat,
  input  logic [LANES*DW-1:0]   wgt,
  output logic [LANES*ACCW-1:0] prod
);

  localparam int PW = 2 * DW;

  logic signed [PW-1:0] p [LANES];

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      p[i] = $signed(feat[i*DW +: DW]) * $signed(wgt[i*DW +: DW]);
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      for (int i = 0; i < LANES; i++) begin
        prod[i*ACCW +: ACCW] <= {{(ACCW-PW){p[i][PW-1]}}, p[i]};
      end
    end
  end

endmodule

// File: rtl/vmac_adder_tree.sv
module vmac_adder_tree #(
  parameter int LANES = 4,
  parameter int ACCW  = 32
) (
  input  logic                  clk,
  input  logic                  en,
  input  logic [LANES*ACCW-1:0] leaves,
  output logic [ACCW-1:0]       root
);

  // Heap layout: node k has children 2k and 2k+1; indices LANES..2*LANES-1
  // are the leaves. Every internal node is a register, so a balanced tree
  // keeps all paths at log2(LANES) cycles.
  logic [ACCW-1:0] nd  [1:LANES-1];
  logic [ACCW-1:0] src [2:2*LANES-1];

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      src[k+LANES] = leaves[k*ACCW +: ACCW];
    end
    for (int k = 2; k < LANES; k++) begin
      src[k] = nd[k];
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      for (int k = 1; k < LANES; k++) begin
        nd[k] <= src[2*k] + src[2*k+1];
      end
    end
  end

  assign root = nd[1];

endmodule

// File: rtl/vmac_accum_ring.sv
module vmac_accum_ring #(
  parameter int ACCW  = 32,
  parameter int DEPTH = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            beat_v,
  input  logic            beat_first,
  input  logic            beat_last,
  input  logic [ACCW-1:0] beat_sum,
  output logic            fin,
  output logic [ACCW-1:0] total
);

  logic [ACCW-1:0] ring [DEPTH];

  // The head takes the tail plus the new sum; the tail was written
  // DEPTH-1 beats ago, so the feedback never spans a single cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ring[i] <= '0;
      fin <= 1'b0;
    end else if (en) begin
      fin <= beat_v && beat_last;
      if (beat_v) begin
        ring[0] <= (beat_first ? '0 : ring[DEPTH-1]) + beat_sum;
        for (int i = 1; i < DEPTH; i++) begin
          ring[i] <= beat_first ? '0 : ring[i-1];
        end
      end
    end
  end

  always_comb begin
    total = '0;
    for (int i = 0; i < DEPTH; i++) total = total + ring[i];
  end

  // R2
  ring_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && beat_v && beat_first) |=> (ring[DEPTH-1] == '0));

  // R3
  fin_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fin) |-> $past(en && beat_v && beat_last));

endmodule

// File: rtl/vmac_requant.sv
module vmac_requant #(
  parameter int ACCW = 32,
  parameter int SHW  = 5,
  parameter int OUTW = 8
) (
  input  logic [ACCW-1:0] total,
  input  logic [ACCW-1:0] bias,
  input  logic            relu_en,
  input  logic [SHW-1:0]  shift,
  output logic [OUTW-1:0] q
);

  localparam int WW = ACCW + 2;
  localparam logic signed [WW-1:0] HI = WW'((64'sd1 <<< (OUTW-1)) - 64'sd1);
  localparam logic signed [WW-1:0] LO = -HI - WW'(1);

  logic signed [ACCW-1:0] biased;
  logic signed [ACCW-1:0] rect;
  logic signed [WW-1:0]   wide;
  logic signed [WW-1:0]   rnd;
  logic signed [WW-1:0]   shd;

  always_comb begin
    biased = $signed(total + bias);
    rect   = (relu_en && biased[ACCW-1]) ? '0 : biased;
    wide   = {{2{rect[ACCW-1]}}, rect};
    rnd    = (shift == '0) ? '0 : (WW'(1) << (shift - SHW'(1)));
    shd    = (wide + rnd) >>> shift;
    if (shd > HI)      q = HI[OUTW-1:0];
    else if (shd < LO) q = LO[OUTW-1:0];
    else               q = shd[OUTW-1:0];
  end

endmodule

// File: rtl/vmac_unit.sv
module vmac_unit
  import vmac_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DW    = 8,
  parameter int ACCW  = 32,
  parameter int SHW   = 5,
  parameter int OUTW  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [LANES*DW-1:0] in_feat,
  input  logic [LANES*DW-1:0] in_wgt,
  input  logic                in_first,
  input  logic                in_last,
  input  logic [ACCW-1:0]     cfg_bias,
  input  logic                cfg_relu_en,
  input  logic [SHW-1:0]      cfg_shift,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [OUTW-1:0]     out_data
);

  localparam int TREE_LAT = $clog2(LANES);
  localparam int RING_D   = TREE_LAT + 1;

  logic                  adv;
  logic [LANES*ACCW-1:0] prod;
  logic [ACCW-1:0]       tree_sum;
  logic                  fin;
  logic [ACCW-1:0]       total;
  logic [OUTW-1:0]       q;
  beat_tag_t             tag_q [0:TREE_LAT];

  // One global advance: everything moves unless a result is blocked.
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  vmac_mul_lanes #(.LANES(LANES), .DW(DW), .ACCW(ACCW)) u_mul (
    .clk (clk),
    .en  (adv),
    .feat(in_feat),
    .wgt (in_wgt),
    .prod(prod)
  );

  vmac_adder_tree #(.LANES(LANES), .ACCW(ACCW)) u_tree (
    .clk   (clk),
    .en    (adv),
    .leaves(prod),
    .root  (tree_sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s <= TREE_LAT; s++) tag_q[s] <= '0;
    end else if (adv) begin
      tag_q[0] <= '{v: in_valid, first: in_first, last: in_last};
      for (int s = 1; s <= TREE_LAT; s++) tag_q[s] <= tag_q[s-1];
    end
  end

  vmac_accum_ring #(.ACCW(ACCW), .DEPTH(RING_D)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (adv),
    .beat_v    (tag_q[TREE_LAT].v),
    .beat_first(tag_q[TREE_LAT].first),
    .beat_last (tag_q[TREE_LAT].last),
    .beat_sum  (tree_sum),
    .fin       (fin),
    .total     (total)
  );

  vmac_requant #(.ACCW(ACCW), .SHW(SHW), .OUTW(OUTW)) u_rq (
    .total  (total),
    .bias   (cfg_bias),
    .relu_en(cfg_relu_en),
    .shift  (cfg_shift),
    .q      (q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (adv) begin
      out_valid <= fin;
      if (fin) out_data <= q;
    end
  end

  // R8
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8
  stall_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R5
  relu_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && adv && cfg_relu_en) |=> !out_data[OUTW-1]);

  // R3
  out_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(fin));

endmodule

// File: tb/sim_vmac_unit.sv
`timescale 1ns/1ps
module sim_vmac_unit;

  localparam int LANES = 4;
  localparam int DW    = 8;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                in_valid = 1'b0;
  logic                in_ready;
  logic [LANES*DW-1:0] in_feat = '0;
  logic [LANES*DW-1:0] in_wgt = '0;
  logic                in_first = 1'b0;
  logic                in_last = 1'b0;
  logic [31:0]         cfg_bias = '0;
  logic                cfg_relu_en = 1'b0;
  logic [4:0]          cfg_shift = '0;
  logic                out_valid;
  logic                out_ready = 1'b1;
  logic [7:0]          out_data;

  int n_chk = 0;
  int n_bad = 0;
  int exp_q[$];
  string req_q[$];
  int acc;

  always #10 clk = ~clk;

  vmac_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_feat(in_feat), .in_wgt(in_wgt),
    .in_first(in_first), .in_last(in_last),
    .cfg_bias(cfg_bias), .cfg_relu_en(cfg_relu_en), .cfg_shift(cfg_shift),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int model(input int sum);
    int     b;
    longint v;
    b = sum + int'(cfg_bias);
    v = longint'(b);
    if (cfg_relu_en && v < 0) v = 0;
    if (cfg_shift != 0) v = v + (64'sd1 <<< (cfg_shift - 1));
    v = v >>> cfg_shift;
    if (v > 127) v = 127;
    if (v < -128) v = -128;
    return int'(v);
  endfunction

  // Compare every transferred result against the expected queue.
  always @(negedge clk) begin
    #2;
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected result", int'($signed(out_data)), 0);
      end else begin
        chk(int'($signed(out_data)) == exp_q[0], req_q[0],
            int'($signed(out_data)), exp_q[0]);
        void'(exp_q.pop_front());
        void'(req_q.pop_front());
      end
    end
  end

  // Offer one beat; returns just after the accepting edge.
  task automatic push(input logic [LANES*DW-1:0] f, input logic [LANES*DW-1:0] w,
                      input bit first, input bit last);
    int s;
    @(negedge clk);
    in_feat = f; in_wgt = w; in_first = first; in_last = last; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    s = 0;
    for (int l = 0; l < LANES; l++) begin
      s = s + int'($signed(f[l*DW +: DW])) * int'($signed(w[l*DW +: DW]));
    end
    acc = first ? s : acc + s;
  endtask

  function automatic logic [LANES*DW-1:0] splat(input int v);
    logic [LANES*DW-1:0] r;
    for (int l = 0; l < LANES; l++) r[l*DW +: DW] = DW'(v);
    return r;
  endfunction

  function automatic logic [LANES*DW-1:0] pat(input int seed, input int b);
    logic [LANES*DW-1:0] r;
    for (int l = 0; l < LANES; l++) r[l*DW +: DW] = DW'(seed * 37 + b * 53 + l * 29);
    return r;
  endfunction

  task automatic expect_now(input string req);
    exp_q.push_back(model(acc));
    req_q.push_back(req);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk(out_valid == 1'b0, "R10 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R10 in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_basic();
    cfg_bias = 0; cfg_relu_en = 0; cfg_shift = 0;
    push(splat(3), splat(2), 1, 0);
    push(splat(-1), splat(5), 0, 1);
    expect_now("R1 two-beat sum");
    drain();
    chk(acc == 4, "R1 bench model sum", acc, 4);
    for (int k = 0; k < 3; k++) begin
      cfg_shift = 5'd4;
      for (int b = 0; b < 3; b++) push(pat(k, b), pat(k + 7, b), b == 0, b == 2);
      expect_now("R1 patterned window");
      drain();
    end
  endtask

  task automatic t_gaps();
    cfg_bias = 0; cfg_relu_en = 0; cfg_shift = 0;
    push(splat(2), splat(3), 1, 0);
    @(negedge clk);
    in_feat = splat(100); in_wgt = splat(100); in_first = 1; in_last = 1;
    repeat (4) @(negedge clk);
    push(splat(1), splat(1), 0, 1);
    expect_now("R9 idle cycles ignored");
    drain();
  endtask

  task automatic t_latency_single();
    int edges;
    cfg_bias = 0; cfg_relu_en = 0; cfg_shift = 0;
    push(splat(5), splat(-2), 1, 1);
    expect_now("R11 single-beat window");
    edges = 0;
    for (int e = 1; e <= 6; e++) begin
      @(posedge clk);
      #1;
      if (out_valid && edges == 0) edges = e;
    end
    chk(edges == 4, "R3 latency edges", edges, 4);
    drain();
    repeat (8) @(negedge clk);
    chk(out_valid == 1'b0, "R3 no extra result", int'(out_valid), 0);
  endtask

  task automatic t_long();
    cfg_bias = 0; cfg_relu_en = 0; cfg_shift = 5'd6;
    for (int b = 0; b < 10; b++) push(pat(3, b), pat(11, b), b == 0, b == 9);
    expect_now("R11 ten-beat window");
    drain();
  endtask

  task automatic t_restart();
    cfg_bias = 0; cfg_relu_en = 0; cfg_shift = 0;
    push(splat(9), splat(9), 1, 0);
    push(splat(9), splat(9), 0, 1);
    expect_now("R2 first window");
    push(splat(1), splat(2), 1, 1);
    expect_now("R2 back-to-back window");
    push(splat(-3), splat(1), 1, 0);
    push(splat(1), splat(1), 0, 1);
    expect_now("R2 third window");
    drain();
  endtask

  task automatic t_bias();
    cfg_relu_en = 0; cfg_shift = 0;
    cfg_bias = 32'd17;
    push(splat(2), splat(2), 1, 1);
    expect_now("R4 positive bias");
    drain();
    cfg_bias = -32'sd40;
    push(splat(2), splat(2), 1, 1);
    expect_now("R4 negative bias");
    drain();
  endtask

  task automatic t_relu();
    cfg_bias = 0; cfg_shift = 0;
    cfg_relu_en = 1;
    push(splat(-4), splat(3), 1, 1);
    expect_now("R5 relu clamps negative");
    drain();
    cfg_relu_en = 0;
    push(splat(-4), splat(3), 1, 1);
    expect_now("R5 relu off passes negative");
    drain();
    cfg_relu_en = 1;
    push(splat(4), splat(3), 1, 1);
    expect_now("R5 relu keeps positive");
    drain();
  endtask

  task automatic t_shift();
    cfg_bias = 0; cfg_relu_en = 0;
    cfg_shift = 5'd1;
    cfg_bias = 32'd1;
    push(splat(1), splat(1), 1, 1);
    expect_now("R6 +5 shift 1 rounds up");
    drain();
    cfg_bias = -32'sd9;
    push(splat(1), splat(1), 1, 1);
    expect_now("R6 -5 shift 1 rounds toward +inf");
    drain();
    cfg_bias = 0; cfg_shift = 5'd3;
    push(splat(5), splat(5), 1, 1);
    expect_now("R6 shift 3");
    drain();
    cfg_shift = 5'd0;
    push(splat(7), splat(1), 1, 1);
    expect_now("R6 shift 0 unchanged");
    drain();
  endtask

  task automatic t_sat();
    cfg_bias = 0; cfg_relu_en = 0; cfg_shift = 0;
    push(splat(127), splat(127), 1, 1);
    expect_now("R7 saturate high");
    drain();
    push(splat(-128), splat(127), 1, 1);
    expect_now("R7 saturate low");
    drain();
    cfg_shift = 5'd2;
    push(splat(-100), splat(100), 1, 0);
    push(splat(-100), splat(100), 0, 1);
    expect_now("R7 saturate low after shift");
    drain();
  endtask

  task automatic t_backpressure();
    logic [7:0] held;
    cfg_bias = 0; cfg_relu_en = 0; cfg_shift = 0;
    @(negedge clk);
    out_ready = 1'b0;
    push(splat(1), splat(3), 1, 1);
    expect_now("R8 first held result");
    push(splat(2), splat(-2), 1, 1);
    expect_now("R8 second result in order");
    repeat (6) @(negedge clk);
    #1;
    held = out_data;
    chk(out_valid == 1'b1, "R8 out_valid held", int'(out_valid), 1);
    chk(in_ready == 1'b0, "R8 in_ready low while blocked", int'(in_ready), 0);
    chk(int'($signed(held)) == exp_q[0], "R8 held data", int'($signed(held)), exp_q[0]);
    repeat (3) @(negedge clk);
    #1;
    chk(out_data == held, "R8 data stable", int'(out_data), int'(held));
    @(negedge clk);
    out_ready = 1'b1;
    drain();
    chk(exp_q.size() == 0, "R8 all results delivered", exp_q.size(), 0);
  endtask

  task automatic run_all();
    t_reset();
    t_basic();
    t_gaps();
    t_latency_single();
    t_long();
    t_restart();
    t_bias();
    t_relu();
    t_shift();
    t_sat();
    t_backpressure();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule